// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Dispatcher

This block arbitrates the interrupt sources of a small 8-bit processor. It keeps a pending-flag register and an enable-mask register. It also holds the master enable bit. Whenever the master enable is on and at least one source is both flagged and enabled, it offers the core a service request that carries a fixed vector address. The lowest-numbered pending source always wins. When the core accepts the request, the dispatcher drops the master enable and retires only the flag of the source it chose. Saving the return address on the stack is left to the core, which starts that sequence when it accepts the request.

The instruction decoder reports every instruction boundary to the block. A plain instruction, an enable, a disable or a halt each has its own strobe. The block applies the one-instruction delay of the enable instruction on these strobes and tracks the halted state. A halt is skipped when an enabled source is already flagged. A halted core wakes as soon as any enabled source is flagged, and it does so whether or not the master enable is on. Peripherals raise flags with one-cycle request pulses, and software may overwrite the flag register at any time.

Top module: `irq_dispatch`

## Requirements
- R1: After reset the flag register reads 0xE0, the mask register reads 0x00, and the master enable and halted state are both clear. Flag bits at and above NUM_SRC always read as 1. A write to either register appears on its read port one cycle later.
- R2: A request pulse on source i sets flag bit i one cycle later. If the pulse lands in the same cycle as a software write that clears that bit, the bit is still set.
- R3: irq_req is high only when the master enable is set and the flag register ANDed with the low NUM_SRC mask bits is nonzero.
- R4: When several sources are flagged and enabled, the lowest-numbered one is chosen. Its vector is VEC_BASE + 8*i, which gives 0x40, 0x48, 0x50, 0x58 and 0x60 for sources 0 to 4.
- R5: A cycle with irq_req and irq_ack both high clears the master enable and clears exactly one flag bit, the one belonging to the chosen source.
- R6: An enable strobe does not change the master enable in the next cycle. The master enable turns on only after the instruction that follows the enable.
- R7: An enable that is directly followed by a disable leaves the master enable clear. An enable that is directly followed by another enable does not set it either, and the second enable then takes effect after its own following instruction.
- R8: An enable directly followed by a halt sets the master enable together with entering the halt.
- R9: A halt strobe while an enabled source is flagged leaves the halted state clear.
- R10: While halted, any flagged and enabled source clears the halted state one cycle later. If the master enable is clear, no request is raised.
- R11: A disable strobe clears the master enable one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag_wr_en | input | 1 | Software write to the flag register |
| flag_wr_data | input | NUM_SRC | Data for the flag write |
| mask_wr_en | input | 1 | Software write to the mask register |
| mask_wr_data | input | 8 | Data for the mask write |
| src_req | input | NUM_SRC | One-cycle request pulses, one per source |
| insn_stb | input | 1 | Boundary of any other instruction |
| ei_stb | input | 1 | Enable instruction executed |
| di_stb | input | 1 | Disable instruction executed |
| halt_stb | input | 1 | Halt instruction executed |
| irq_ack | input | 1 | Core accepts the offered request |
| flag_rd | output | 8 | Flag register read view |
| mask_rd | output | 8 | Mask register read view |
| ime | output | 1 | Master enable |
| halted | output | 1 | Core is halted |
| irq_req | output | 1 | Service request to the core |
| irq_vec | output | 8 | Vector address of the chosen source |

## Verification
The bench uses the default parameters: five sources, vector base 0x40 and step 8. These values make all five vectors and the three read-as-one flag bits observable. With five sources, random flag patterns often leave two or three sources pending at once, so the lowest-bit priority is exercised many times. The directed sequences cover each ordering of enable, disable and halt, and wake-up from halt both with the master enable set and with it clear.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
   // Kind of instruction boundary reported by the decoder
   typedef enum logic [2:0] {
      BND_NONE  = 3'd0,
      BND_PLAIN = 3'd1,
      BND_EI    = 3'd2,
      BND_DI    = 3'd3,
      BND_HALT  = 3'd4
   } bnd_kind_t;
endpackage

// File: rtl/irq_dispatch_flags.sv
module irq_dispatch_flags #(
   parameter int NUM_SRC = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [NUM_SRC-1:0] wr_data,
   input  logic [NUM_SRC-1:0] set_req,
   input  logic [NUM_SRC-1:0] clr_req,
   output logic [NUM_SRC-1:0] flags
);
   logic [NUM_SRC-1:0] flags_n;

   always_comb begin
      flags_n = wr_en ? wr_data : flags;
      flags_n = flags_n & ~clr_req;
      flags_n = flags_n | set_req;   // hardware pulse has the last word
   end

   always_ff @(posedge clk) begin
      if (!rst_n) flags <= '0;
      else        flags <= flags_n;
   end
endmodule

// File: rtl/irq_dispatch_prio.sv
module irq_dispatch_prio #(
   parameter int NUM_SRC  = 5,
   parameter int REG_W    = 8,
   parameter int VEC_BASE = 'h40,
   parameter int VEC_STEP = 8
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic [NUM_SRC-1:0] grant,
   output logic [REG_W-1:0]   vec
);
   logic [NUM_SRC:0] lower;   // any pending source below index i

   assign lower[0] = 1'b0;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
      assign lower[i+1] = lower[i] | pend[i];
      assign grant[i]   = pend[i] & ~lower[i];
   end

   always_comb begin
      vec = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (grant[i]) vec = vec | REG_W'(VEC_BASE + i * VEC_STEP);
      end
   end
endmodule

// File: rtl/irq_dispatch_master.sv
module irq_dispatch_master
   import irq_dispatch_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  bnd_kind_t kind,
   input  logic      pend_any,
   input  logic      take,
   output logic      ime,
   output logic      halted
);
   logic ei_wait;
   logic ime_n, ei_wait_n, halted_n;

   always_comb begin
      ime_n     = ime;
      ei_wait_n = ei_wait;
      case (kind)
         BND_EI: ei_wait_n = 1'b1;            // a repeated EI only re-arms
         BND_DI: begin
            ei_wait_n = 1'b0;
            ime_n     = 1'b0;
         end
         BND_PLAIN, BND_HALT: begin
            if (ei_wait) begin
               ime_n     = 1'b1;
               ei_wait_n = 1'b0;
            end
         end
         default: ;
      endcase
      if (take) ime_n = 1'b0;

      halted_n = halted;
      if (kind == BND_HALT && !pend_any) halted_n = 1'b1;
      else if (pend_any)                 halted_n = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ime     <= 1'b0;
         ei_wait <= 1'b0;
         halted  <= 1'b0;
      end else begin
         ime     <= ime_n;
         ei_wait <= ei_wait_n;
         halted  <= halted_n;
      end
   end
endmodule

// File: rtl/irq_dispatch.sv
module irq_dispatch
   import irq_dispatch_pkg::*;
#(
   parameter int NUM_SRC  = 5,
   parameter int REG_W    = 8,
   parameter int VEC_BASE = 'h40,
   parameter int VEC_STEP = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flag_wr_en,
   input  logic [NUM_SRC-1:0] flag_wr_data,
   input  logic               mask_wr_en,
   input  logic [REG_W-1:0]   mask_wr_data,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               insn_stb,
   input  logic               ei_stb,
   input  logic               di_stb,
   input  logic               halt_stb,
   input  logic               irq_ack,
   output logic [REG_W-1:0]   flag_rd,
   output logic [REG_W-1:0]   mask_rd,
   output logic               ime,
   output logic               halted,
   output logic               irq_req,
   output logic [REG_W-1:0]   irq_vec
);
   localparam int VEC_LAST = VEC_BASE + (NUM_SRC - 1) * VEC_STEP;

   if (NUM_SRC < 1 || NUM_SRC > REG_W) begin : g_bad_src
      $error("irq_dispatch: NUM_SRC must lie in 1..REG_W");
   end
   if (VEC_LAST >= (1 << REG_W)) begin : g_bad_vec
      $error("irq_dispatch: vector table exceeds REG_W bits");
   end

   logic [NUM_SRC-1:0] flags, pend, grant;
   logic [REG_W-1:0]   mask_q;
   logic               take;
   bnd_kind_t          kind;

   always_ff @(posedge clk) begin
      if (!rst_n)          mask_q <= '0;
      else if (mask_wr_en) mask_q <= mask_wr_data;
   end

   assign pend = flags & mask_q[NUM_SRC-1:0];
   assign take = irq_req & irq_ack;

   always_comb begin
      if      (halt_stb) kind = BND_HALT;
      else if (di_stb)   kind = BND_DI;
      else if (ei_stb)   kind = BND_EI;
      else if (insn_stb) kind = BND_PLAIN;
      else               kind = BND_NONE;
   end

   irq_dispatch_flags #(.NUM_SRC(NUM_SRC)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (flag_wr_en),
      .wr_data (flag_wr_data),
      .set_req (src_req),
      .clr_req (grant & {NUM_SRC{take}}),
      .flags   (flags)
   );

   irq_dispatch_prio #(
      .NUM_SRC(NUM_SRC), .REG_W(REG_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
   ) u_prio (
      .pend  (pend),
      .grant (grant),
      .vec   (irq_vec)
   );

   irq_dispatch_master u_master (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind     (kind),
      .pend_any (|pend),
      .take     (take),
      .ime      (ime),
      .halted   (halted)
   );

   assign irq_req = ime & (|pend);
   assign mask_rd = mask_q;

   if (NUM_SRC < REG_W) begin : g_pad
      assign flag_rd = {{(REG_W-NUM_SRC){1'b1}}, flags};
   end else begin : g_full
      assign flag_rd = flags;
   end
endmodule

// File: rtl/irq_dispatch_chk.sv
module irq_dispatch_chk #(
   parameter int NUM_SRC  = 5,
   parameter int REG_W    = 8,
   parameter int VEC_BASE = 'h40,
   parameter int VEC_STEP = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               flag_wr_en,
   input logic [NUM_SRC-1:0] flag_wr_data,
   input logic               mask_wr_en,
   input logic [REG_W-1:0]   mask_wr_data,
   input logic [NUM_SRC-1:0] src_req,
   input logic               insn_stb,
   input logic               ei_stb,
   input logic               di_stb,
   input logic               halt_stb,
   input logic               irq_ack,
   input logic [REG_W-1:0]   flag_rd,
   input logic [REG_W-1:0]   mask_rd,
   input logic               ime,
   input logic               halted,
   input logic               irq_req,
   input logic [REG_W-1:0]   irq_vec
);
   logic [NUM_SRC-1:0] pend_w;
   logic               vec_ok;
   int                 off, idx;

   assign pend_w = flag_rd[NUM_SRC-1:0] & mask_rd[NUM_SRC-1:0];

   always_comb begin
      vec_ok = 1'b0;
      idx    = 0;
      off    = int'(irq_vec) - VEC_BASE;
      if (off >= 0 && (off % VEC_STEP) == 0 && (off / VEC_STEP) < NUM_SRC) begin
         idx    = off / VEC_STEP;
         vec_ok = pend_w[idx];
         for (int j = 0; j < NUM_SRC; j++) begin
            if (j < idx && pend_w[j]) vec_ok = 1'b0;
         end
      end
   end

   // R1
   mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mask_wr_en |=> mask_rd == $past(mask_wr_data));
   // R1
   flag_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr_en && !irq_ack |=>
         flag_rd[NUM_SRC-1:0] == ($past(flag_wr_data) | $past(src_req)));
   // R2
   pulse_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|src_req) |=> (flag_rd[NUM_SRC-1:0] & $past(src_req)) == $past(src_req));
   // R3
   req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> ime && (|pend_w));
   // R4
   lowest_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |-> vec_ok);
   // R5
   ack_drops_ime_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> !ime);
   // R5
   ack_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack && !flag_wr_en && src_req == '0 |=>
         $countones(flag_rd[NUM_SRC-1:0]) == $countones($past(flag_rd[NUM_SRC-1:0])) - 1);
   // R6
   ei_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_stb && !di_stb && !halt_stb) ##1
      (insn_stb && !ei_stb && !di_stb && !halt_stb && !(irq_req && irq_ack)) |=> ime);
   // R7
   ei_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ime && ei_stb && !halt_stb |=> !ime);
   // R8
   ei_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ei_stb && !di_stb && !halt_stb) ##1 (halt_stb && !(irq_req && irq_ack)) |=> ime);
   // R9
   halt_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt_stb && (|pend_w) |=> !halted);
   // R10
   halt_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halted && (|pend_w) |=> !halted);
   // R11
   di_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      di_stb && !halt_stb |=> !ime);
endmodule

bind irq_dispatch irq_dispatch_chk #(
   .NUM_SRC(NUM_SRC), .REG_W(REG_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
) u_chk (.*);

// File: tb/irq_dispatch_test.sv
`timescale 1ns/1ps
module irq_dispatch_test;
   localparam int NS = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          fw_en = 0, mw_en = 0, ins = 0, ei = 0, di = 0, hl = 0, ack = 0;
   logic [NS-1:0] fw_d = '0, sreq = '0;
   logic [7:0]    mw_d = '0;
   logic [7:0]    flag_rd, mask_rd, irq_vec;
   logic          ime, halted, irq_req;

   int checks = 0, errors = 0;

   // reference state
   logic [NS-1:0] m_if = '0;
   logic [7:0]    m_ie = '0;
   logic          m_ime = 0, m_eip = 0, m_halt = 0;

   always #10 clk = ~clk;   // 50 MHz

   irq_dispatch uut (
      .clk(clk), .rst_n(rst_n),
      .flag_wr_en(fw_en), .flag_wr_data(fw_d),
      .mask_wr_en(mw_en), .mask_wr_data(mw_d),
      .src_req(sreq), .insn_stb(ins), .ei_stb(ei), .di_stb(di), .halt_stb(hl),
      .irq_ack(ack),
      .flag_rd(flag_rd), .mask_rd(mask_rd), .ime(ime), .halted(halted),
      .irq_req(irq_req), .irq_vec(irq_vec)
   );

   function automatic logic [NS-1:0] m_pend();
      return m_if & m_ie[NS-1:0];
   endfunction

   function automatic logic m_req();
      return m_ime && (m_pend() != '0);
   endfunction

   function automatic int m_idx();
      logic [NS-1:0] p = m_pend();
      for (int i = 0; i < NS; i++) if (p[i]) return i;
      return 0;
   endfunction

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      logic [NS-1:0] nif;
      logic          take = ack && m_req();
      logic          pany = (m_pend() != '0);
      logic          nime = m_ime, neip = m_eip, nhalt = m_halt;
      nif = fw_en ? fw_d : m_if;
      if (take) nif[m_idx()] = 1'b0;
      nif = nif | sreq;
      if (hl) begin
         if (m_eip) begin nime = 1; neip = 0; end
      end else if (di) begin
         nime = 0; neip = 0;
      end else if (ei) begin
         neip = 1;
      end else if (ins) begin
         if (m_eip) begin nime = 1; neip = 0; end
      end
      if (take) nime = 0;
      if (hl && !pany) nhalt = 1;
      else if (pany)   nhalt = 0;
      m_if = nif;
      if (mw_en) m_ie = mw_d;
      m_ime = nime; m_eip = neip; m_halt = nhalt;
   endtask

   task automatic compare_all();
      chk("R1 flag_rd", int'(flag_rd), int'({3'b111, m_if}));
      chk("R1 mask_rd", int'(mask_rd), int'(m_ie));
      chk("R6 ime", int'(ime), int'(m_ime));
      chk("R9 halted", int'(halted), int'(m_halt));
      chk("R3 irq_req", int'(irq_req), int'(m_req()));
      if (m_req()) chk("R4 irq_vec", int'(irq_vec), 'h40 + 8 * m_idx());
   endtask

   // inputs are driven at the falling edge; one call covers one clock
   task automatic tick();
      model_step();
      @(posedge clk);
      @(negedge clk);
      fw_en = 0; mw_en = 0; ins = 0; ei = 0; di = 0; hl = 0; ack = 0;
      sreq = '0; fw_d = '0; mw_d = '0;
      compare_all();
   endtask

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk("R1 reset flag", int'(flag_rd), 'hE0);
      chk("R1 reset mask", int'(mask_rd), 0);
      chk("R1 reset ime", int'(ime), 0);
      chk("R1 reset halted", int'(halted), 0);

      // R2 pulse beats a clearing write
      fw_en = 1; fw_d = '0; sreq = 5'b00100; tick();
      chk("R2 pulse vs write", int'(flag_rd), 'hE4);

      // R3 pending but master enable clear
      mw_en = 1; mw_d = 8'h1F; fw_en = 1; fw_d = 5'b01010; tick();
      chk("R3 no req with ime clear", int'(irq_req), 0);

      // R6 enable delay
      ei = 1; tick();
      chk("R6 ime still clear", int'(ime), 0);
      ins = 1; tick();
      chk("R6 ime after next insn", int'(ime), 1);
      chk("R4 lowest wins vec", int'(irq_vec), 'h48);

      // R5 acknowledge
      ack = 1; tick();
      chk("R5 ime dropped", int'(ime), 0);
      chk("R5 only chosen bit cleared", int'(flag_rd), 'hE8);

      // R7 EI then DI, EI then EI
      ei = 1; tick(); di = 1; tick();
      chk("R7 ei-di", int'(ime), 0);
      ei = 1; tick(); ei = 1; tick();
      chk("R7 ei-ei", int'(ime), 0);
      ins = 1; tick();
      chk("R7 second ei acts", int'(ime), 1);
      chk("R4 vec source 3", int'(irq_vec), 'h58);
      di = 1; tick();
      chk("R11 di clears", int'(ime), 0);

      // R8 EI then HALT, R10 wake with dispatch
      fw_en = 1; fw_d = '0; tick();
      ei = 1; tick(); hl = 1; tick();
      chk("R8 halted", int'(halted), 1);
      chk("R8 ime with halt", int'(ime), 1);
      sreq = 5'b00001; tick();
      chk("R10 req while halted", int'(irq_req), 1);
      chk("R4 vec source 0", int'(irq_vec), 'h40);
      tick();
      chk("R10 woke", int'(halted), 0);
      ack = 1; tick();

      // R9 halt skipped with pending, R10 no dispatch
      sreq = 5'b10000; tick();
      hl = 1; tick();
      chk("R9 halt skipped", int'(halted), 0);
      chk("R10 no req ime clear", int'(irq_req), 0);
      fw_en = 1; fw_d = '0; tick();
      hl = 1; tick();
      chk("R9 halt entered", int'(halted), 1);
      sreq = 5'b00100; tick(); tick();
      chk("R10 woke without ime", int'(halted), 0);
      chk("R10 resumed no dispatch", int'(irq_req), 0);

      // random phase
      for (int n = 0; n < 4000; n++) begin
         int r = int'($urandom % 16);
         if (m_req() && ($urandom % 3 == 0)) ack = 1;
         else if (r >= 6 && r <= 9) ins = 1;
         else if (r == 10) ei = 1;
         else if (r == 11) di = 1;
         else if (r == 12) hl = 1;
         if ($urandom % 12 == 0) begin fw_en = 1; fw_d = NS'($urandom); end
         if ($urandom % 16 == 0) begin mw_en = 1; mw_d = 8'($urandom); end
         if ($urandom % 5 == 0) sreq = NS'($urandom);
         tick();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule